// File: doc/BRIEF.md
# Per-Core Snooping Coherence Controller with Shared-Line Cache

This block is the coherence controller for one core of a bus-based chip multiprocessor. It sits between the core and a shared bus. It owns two small direct-mapped stores. The private store holds lines that only this core may hold: invalid, exclusive-clean or exclusive-dirty. The shared-line store holds lines that several cores may hold at once. A line in the shared-line store is never also valid in any private store. Shared lines are kept current by write-through updates rather than by invalidation.

A processor access looks in the shared-line store first, then in the private store. Only if both miss does the controller go to the bus. Bus tenure is granted by an external single-grant arbiter. The rest of the system answers each read with the data and two flags: whether a remote cache held the line, and whether that copy was dirty. A remote hit makes the line shared locally, and the remote private copy is dropped. Dirty data and writes to shared lines are written through to memory. The controller also snoops other cores' bus transactions. It gives up its private lines to them, and it applies their write-through updates to its own shared lines.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every private line is invalid and the shared-line store is empty. `cpu_stall`, `cpu_done`, `bus_req`, `snp_hit` and `snp_dirty` are low, so the first access to any address goes to the bus.
- R2: An access that hits in the shared-line store is served from it. A read hit completes with `cpu_done` one cycle after acceptance, with no bus request and with `cpu_stall` low.
- R3: A read miss with no remote holder (`bus_shd`=0) issues one bus read (`bus_cmd`=0) and installs the line exclusive-clean. A later read of it completes locally with no bus traffic.
- R4: A read miss answered with `bus_shd`=1 and `bus_dty`=1 installs the supplied data as a shared line. It then issues one write-through (`bus_cmd`=2) of that data, and the data goes to the core.
- R5: A write that hits an exclusive-dirty private line updates it with no bus traffic.
- R6: A write that hits an exclusive-clean private line updates it with no bus traffic and makes it dirty. A later snooped read of that line reports it dirty.
- R7: A write that hits a shared line updates the local copy and issues one write-through (`bus_cmd`=2) of the new data, with `cpu_stall` held until it completes. The line stays valid afterwards.
- R8: A write miss answered with `bus_shd`=1 issues a read-for-ownership (`bus_cmd`=1). It installs the written data as a shared line and then writes it through (`bus_cmd`=2).
- R9: A write miss with no remote holder issues a read-for-ownership (`bus_cmd`=1) and installs the line exclusive-dirty, holding the written data.
- R10: A snooped read (`snp_cmd`=0) or read-for-ownership (`snp_cmd`=1) that hits a private line does three things on the next cycle: it drives `snp_hit`, drives `snp_dirty` if the line was dirty, and drives the line data on `snp_data`. The private line becomes invalid.
- R11: A snooped read of a shared line reports a hit that is not dirty and keeps the line. A snooped write-through (`snp_cmd`=2) to a shared line replaces the local copy's data.
- R12: A miss whose private victim slot holds a dirty line of another address first writes that victim back (`bus_cmd`=3, victim address and data), then issues the fill.
- R13: `cpu_stall` rises the cycle after a miss is accepted. It stays high until the final bus transaction of the access is acknowledged, and it is never high together with `cpu_done`. While granted, `bus_cmd` is stable. A processor request is not accepted in a cycle with `snp_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Line (word) address |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_stall | output | 1 | High while a bus transaction for the access is outstanding |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 write-through, 3 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Data for write-through and write-back |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_ack | input | 1 | Transaction complete, response valid |
| bus_rdata | input | DW | Fill data |
| bus_shd | input | 1 | A remote cache held the line |
| bus_dty | input | 1 | The remote copy was dirty |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | AW | Snooped address |
| snp_wdata | input | DW | Snooped write data |
| snp_hit | output | 1 | This core holds the snooped line (cycle after `snp_valid`) |
| snp_dirty | output | 1 | The held line was dirty |
| snp_data | output | DW | Data of the held line |

## Verification
The embedded properties check every cycle that stall and completion never overlap and that the command stays fixed under grant. They also check that a write-back always targets a victim in the accessed slot, that a write-through only goes out for a line present in the shared-line store, that snoop and processor never write a store in the same cycle, and that a dirty snoop reply is always a hit. The state transitions themselves are shown only by the directed scenarios, because the line states are not visible at the ports. These are exclusive-clean to dirty on a write, private to shared on a remote hit, invalidation by a snoop, and the victim write-back before a fill. The scenarios observe them through later bus traffic, snoop replies and completion latency.

// File: rtl/coh_pkg.sv
package coh_pkg;
  // bus and snoop command encoding
  localparam logic [1:0] CMD_RD  = 2'd0;
  localparam logic [1:0] CMD_RDX = 2'd1;
  localparam logic [1:0] CMD_WT  = 2'd2;
  localparam logic [1:0] CMD_WB  = 2'd3;
  // private line states
  localparam logic [1:0] L_PI = 2'd0;
  localparam logic [1:0] L_PE = 2'd1;
  localparam logic [1:0] L_PD = 2'd2;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WT} fsm_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store #(
  parameter int IW   = 3,
  parameter int TAGW = 5,
  parameter int STW  = 2,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   a_idx,
  output logic [TAGW-1:0] a_tag,
  output logic [STW-1:0]  a_st,
  output logic [DW-1:0]   a_data,
  input  logic [IW-1:0]   b_idx,
  output logic [TAGW-1:0] b_tag,
  output logic [STW-1:0]  b_st,
  output logic [DW-1:0]   b_data,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [TAGW-1:0] wr_tag,
  input  logic [STW-1:0]  wr_st,
  input  logic [DW-1:0]   wr_data
);
  localparam int LINES = 1 << IW;

  logic [TAGW-1:0] tag_mem  [LINES];
  logic [DW-1:0]   data_mem [LINES];
  logic [STW-1:0]  st_mem   [LINES];

  // tag and data: no reset, single write port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  // state bits cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_mem[i] <= '0;
    end else if (wr_en) begin
      st_mem[wr_idx] <= wr_st;
    end
  end

  assign a_tag  = tag_mem[a_idx];
  assign a_st   = st_mem[a_idx];
  assign a_data = data_mem[a_idx];
  assign b_tag  = tag_mem[b_idx];
  assign b_st   = st_mem[b_idx];
  assign b_data = data_mem[b_idx];
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop #(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int PIW = 3,
  parameter int SIW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [AW-1:0]     snp_addr,
  input  logic [DW-1:0]     snp_wdata,
  input  logic [1:0]        p_st,
  input  logic [AW-PIW-1:0] p_tag,
  input  logic [DW-1:0]     p_data,
  input  logic              s_vld,
  input  logic [AW-SIW-1:0] s_tag,
  input  logic [DW-1:0]     s_data,
  output logic              p_inv,
  output logic              s_upd,
  output logic              snp_hit,
  output logic              snp_dirty,
  output logic [DW-1:0]     snp_data
);
  import coh_pkg::*;

  logic is_read, p_match, s_match;

  assign is_read = (snp_cmd == CMD_RD) || (snp_cmd == CMD_RDX);
  assign p_match = (p_st != L_PI) && (p_tag == snp_addr[AW-1:PIW]);
  assign s_match = s_vld && (s_tag == snp_addr[AW-1:SIW]);

  // private copy is surrendered to the requester
  assign p_inv = snp_valid && is_read && p_match;
  // shared copy follows remote write-through
  assign s_upd = snp_valid && (snp_cmd == CMD_WT) && s_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_hit   <= 1'b0;
      snp_dirty <= 1'b0;
      snp_data  <= '0;
    end else begin
      snp_hit   <= snp_valid && is_read && (p_match || s_match);
      snp_dirty <= snp_valid && is_read && p_match && (p_st == L_PD);
      if (snp_valid && is_read && p_match)      snp_data <= p_data;
      else if (snp_valid && is_read && s_match) snp_data <= s_data;
      else                                      snp_data <= '0;
    end
  end

  // R10
  dirty_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
    snp_dirty |-> snp_hit);
endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int P_LINES = 8,
  parameter int S_LINES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_done,
  output logic          cpu_stall,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_shd,
  input  logic          bus_dty,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_wdata,
  output logic          snp_hit,
  output logic          snp_dirty,
  output logic [DW-1:0] snp_data
);
  import coh_pkg::*;

  localparam int PIW = $clog2(P_LINES);
  localparam int SIW = $clog2(S_LINES);
  localparam int PTW = AW - PIW;
  localparam int STG = AW - SIW;

  fsm_e fsm_q;
  logic          op_we;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata, wt_data;

  logic [AW-1:0] look_addr;
  logic [PTW-1:0] p_a_tag, p_b_tag;
  logic [1:0]     p_a_st, p_b_st;
  logic [DW-1:0]  p_a_data, p_b_data;
  logic [STG-1:0] s_a_tag, s_b_tag;
  logic [0:0]     s_a_st, s_b_st;
  logic [DW-1:0]  s_a_data, s_b_data;

  logic p_hit, s_hit, victim_dirty, accept;

  // processor-side write requests
  logic           f_p_wr, f_s_wr;
  logic [1:0]     f_p_st;
  logic [PTW-1:0] f_p_tag;
  logic [DW-1:0]  f_p_data, f_s_data;
  // snoop-side write requests
  logic sn_p_inv, sn_s_upd;
  // merged write ports
  logic           p_wr_en, s_wr_en;
  logic [PIW-1:0] p_wr_idx;
  logic [SIW-1:0] s_wr_idx;
  logic [PTW-1:0] p_wr_tag;
  logic [STG-1:0] s_wr_tag;
  logic [1:0]     p_wr_st;
  logic [DW-1:0]  p_wr_data, s_wr_data;

  assign look_addr    = (fsm_q == F_IDLE) ? cpu_addr : op_addr;
  assign p_hit        = (p_a_st != L_PI) && (p_a_tag == look_addr[AW-1:PIW]);
  assign s_hit        = s_a_st[0] && (s_a_tag == look_addr[AW-1:SIW]);
  assign victim_dirty = (p_a_st == L_PD) && !p_hit;
  assign accept       = (fsm_q == F_IDLE) && cpu_req && !snp_valid && !cpu_done;

  coh_line_store #(.IW(PIW), .TAGW(PTW), .STW(2), .DW(DW)) u_priv (
    .clk(clk), .rst(rst),
    .a_idx(look_addr[PIW-1:0]), .a_tag(p_a_tag), .a_st(p_a_st), .a_data(p_a_data),
    .b_idx(snp_addr[PIW-1:0]),  .b_tag(p_b_tag), .b_st(p_b_st), .b_data(p_b_data),
    .wr_en(p_wr_en), .wr_idx(p_wr_idx), .wr_tag(p_wr_tag), .wr_st(p_wr_st),
    .wr_data(p_wr_data)
  );

  coh_line_store #(.IW(SIW), .TAGW(STG), .STW(1), .DW(DW)) u_shr (
    .clk(clk), .rst(rst),
    .a_idx(look_addr[SIW-1:0]), .a_tag(s_a_tag), .a_st(s_a_st), .a_data(s_a_data),
    .b_idx(snp_addr[SIW-1:0]),  .b_tag(s_b_tag), .b_st(s_b_st), .b_data(s_b_data),
    .wr_en(s_wr_en), .wr_idx(s_wr_idx), .wr_tag(s_wr_tag), .wr_st(1'b1),
    .wr_data(s_wr_data)
  );

  coh_snoop #(.AW(AW), .DW(DW), .PIW(PIW), .SIW(SIW)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_wdata(snp_wdata),
    .p_st(p_b_st), .p_tag(p_b_tag), .p_data(p_b_data),
    .s_vld(s_b_st[0]), .s_tag(s_b_tag), .s_data(s_b_data),
    .p_inv(sn_p_inv), .s_upd(sn_s_upd),
    .snp_hit(snp_hit), .snp_dirty(snp_dirty), .snp_data(snp_data)
  );

  // processor-side array updates
  always_comb begin
    f_p_wr   = 1'b0;
    f_s_wr   = 1'b0;
    f_p_st   = L_PI;
    f_p_tag  = look_addr[AW-1:PIW];
    f_p_data = cpu_wdata;
    f_s_data = cpu_wdata;
    case (fsm_q)
      F_IDLE: begin
        if (accept && cpu_we) begin
          if (s_hit) begin
            f_s_wr = 1'b1;
          end else if (p_hit) begin
            f_p_wr = 1'b1;
            f_p_st = L_PD;
          end
        end
      end
      F_REQ: begin
        if (bus_ack) begin
          if (bus_cmd == CMD_WB) begin
            f_p_wr   = 1'b1;
            f_p_st   = L_PI;
            f_p_tag  = p_a_tag;
            f_p_data = p_a_data;
          end else if (bus_shd) begin
            f_s_wr   = 1'b1;
            f_s_data = op_we ? op_wdata : bus_rdata;
          end else begin
            f_p_wr   = 1'b1;
            f_p_st   = op_we ? L_PD : L_PE;
            f_p_data = op_we ? op_wdata : bus_rdata;
          end
        end
      end
      default: ;
    endcase
  end

  // merge: snoop and processor never update in the same cycle
  assign p_wr_en   = sn_p_inv | f_p_wr;
  assign p_wr_idx  = sn_p_inv ? snp_addr[PIW-1:0] : look_addr[PIW-1:0];
  assign p_wr_tag  = sn_p_inv ? p_b_tag : f_p_tag;
  assign p_wr_st   = sn_p_inv ? L_PI : f_p_st;
  assign p_wr_data = sn_p_inv ? p_b_data : f_p_data;
  assign s_wr_en   = sn_s_upd | f_s_wr;
  assign s_wr_idx  = sn_s_upd ? snp_addr[SIW-1:0] : look_addr[SIW-1:0];
  assign s_wr_tag  = sn_s_upd ? s_b_tag : look_addr[AW-1:SIW];
  assign s_wr_data = sn_s_upd ? snp_wdata : f_s_data;

  // control sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q     <= F_IDLE;
      op_we     <= 1'b0;
      op_addr   <= '0;
      op_wdata  <= '0;
      wt_data   <= '0;
      cpu_rdata <= '0;
      cpu_done  <= 1'b0;
      cpu_stall <= 1'b0;
      bus_req   <= 1'b0;
      bus_cmd   <= CMD_RD;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (fsm_q)
        F_IDLE: begin
          if (accept) begin
            op_we    <= cpu_we;
            op_addr  <= cpu_addr;
            op_wdata <= cpu_wdata;
            if (s_hit) begin
              if (cpu_we) begin
                wt_data   <= cpu_wdata;
                cpu_rdata <= cpu_wdata;
                cpu_stall <= 1'b1;
                fsm_q     <= F_WT;
              end else begin
                cpu_rdata <= s_a_data;
                cpu_done  <= 1'b1;
              end
            end else if (p_hit) begin
              cpu_rdata <= cpu_we ? cpu_wdata : p_a_data;
              cpu_done  <= 1'b1;
            end else begin
              cpu_stall <= 1'b1;
              fsm_q     <= F_REQ;
            end
          end
        end
        F_REQ: begin
          if (bus_ack) begin
            bus_req <= 1'b0;
            if (bus_cmd != CMD_WB) begin
              cpu_rdata <= op_we ? op_wdata : bus_rdata;
              if (bus_shd && (op_we || bus_dty)) begin
                wt_data <= op_we ? op_wdata : bus_rdata;
                fsm_q   <= F_WT;
              end else begin
                cpu_done  <= 1'b1;
                cpu_stall <= 1'b0;
                fsm_q     <= F_IDLE;
              end
            end
          end else if (!bus_gnt) begin
            bus_req   <= 1'b1;
            bus_wdata <= p_a_data;
            if (victim_dirty) begin
              bus_cmd  <= CMD_WB;
              bus_addr <= {p_a_tag, op_addr[PIW-1:0]};
            end else begin
              bus_cmd  <= op_we ? CMD_RDX : CMD_RD;
              bus_addr <= op_addr;
            end
          end
        end
        F_WT: begin
          if (bus_ack) begin
            bus_req   <= 1'b0;
            cpu_done  <= 1'b1;
            cpu_stall <= 1'b0;
            fsm_q     <= F_IDLE;
          end else if (!bus_gnt) begin
            bus_req   <= 1'b1;
            bus_cmd   <= CMD_WT;
            bus_addr  <= op_addr;
            bus_wdata <= wt_data;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!bus_req && !cpu_stall && !cpu_done));
  // R13
  stall_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpu_done && cpu_stall));
  // R13
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && !bus_ack) |=> $stable(bus_cmd) && $stable(bus_addr));
  // R12
  wb_victim_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_cmd == CMD_WB) |->
      (bus_addr[PIW-1:0] == op_addr[PIW-1:0]) && (bus_addr != op_addr));
  // R7
  wt_line_shared_chk: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == F_WT && bus_req) |-> s_hit);
  // R10
  one_writer_chk: assert property (@(posedge clk) disable iff (rst)
    !(sn_p_inv && f_p_wr) && !(sn_s_upd && f_s_wr));
endmodule

// File: tb/sim_coh_snoop_ctrl.sv
`timescale 1ns/100ps
module sim_coh_snoop_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_done, cpu_stall;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_gnt = 1'b0, bus_ack = 1'b0, bus_shd = 1'b0, bus_dty = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_wdata = '0;
  logic snp_hit, snp_dirty;
  logic [DW-1:0] snp_data;

  always #2.5 clk = ~clk;

  coh_snoop_ctrl #(.AW(AW), .DW(DW), .P_LINES(8), .S_LINES(4)) u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .cpu_stall(cpu_stall), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .bus_shd(bus_shd), .bus_dty(bus_dty), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_wdata(snp_wdata), .snp_hit(snp_hit),
    .snp_dirty(snp_dirty), .snp_data(snp_data)
  );

  int total = 0, bad = 0;
  logic [DW-1:0] mem [256];
  // remote-holder response for the next fill
  logic rs_shd = 1'b0, rs_dty = 1'b0;
  logic [DW-1:0] rs_data = '0;
  // transaction log of the current access
  int n_log = 0;
  logic [1:0]    lg_cmd  [8];
  logic [AW-1:0] lg_addr [8];
  logic [DW-1:0] lg_data [8];
  // results of the last access / snoop
  logic [DW-1:0] r_data;
  int r_lat;
  bit r_stall;
  logic s_hit, s_dirty;
  logic [DW-1:0] s_data;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // arbiter, memory and remote caches
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i);
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        bus_gnt = 1'b0;
      end else if (bus_gnt) begin
        if (n_log < 8) begin
          lg_cmd[n_log] = bus_cmd;
          lg_addr[n_log] = bus_addr;
          lg_data[n_log] = bus_wdata;
        end
        n_log++;
        if (bus_cmd >= 2'd2) begin
          mem[bus_addr] = bus_wdata;
          bus_shd = 1'b0; bus_dty = 1'b0; bus_rdata = '0;
        end else begin
          bus_shd = rs_shd; bus_dty = rs_dty;
          bus_rdata = rs_shd ? rs_data : mem[bus_addr];
        end
        bus_ack = 1'b1;
      end else if (bus_req) begin
        bus_gnt = 1'b1;
      end
    end
  end

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    n_log = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    r_lat = 0; r_stall = 0;
    do begin
      @(negedge clk);
      r_lat++;
      if (cpu_stall) r_stall = 1;
    end while (!cpu_done && r_lat < 300);
    r_data = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_wdata = d;
    @(negedge clk);
    snp_valid = 1'b0;
    s_hit = snp_hit; s_dirty = snp_dirty; s_data = snp_data;
  endtask

  task automatic t_reset;
    chk("R1 stall low", cpu_stall == 0, cpu_stall, 0);
    chk("R1 done low", cpu_done == 0, cpu_done, 0);
    chk("R1 bus idle", bus_req == 0, bus_req, 0);
    chk("R1 snoop quiet", snp_hit == 0 && snp_dirty == 0, snp_hit, 0);
  endtask

  task automatic t_read_fill;
    access(0, 8'h10, '0);
    chk("R1 first access misses", n_log == 1, n_log, 1);
    chk("R3 read cmd", lg_cmd[0] == 2'd0 && lg_addr[0] == 8'h10, lg_cmd[0], 0);
    chk("R3 fill data", r_data == 16'h1010, r_data, 16'h1010);
    chk("R13 stall on miss", r_stall == 1, r_stall, 1);
    access(0, 8'h10, '0);
    chk("R3 local hit no bus", n_log == 0, n_log, 0);
    chk("R3 hit data", r_data == 16'h1010, r_data, 16'h1010);
    chk("R13 hit latency", r_lat == 1 && r_stall == 0, r_lat, 1);
  endtask

  task automatic t_write_pe;
    access(1, 8'h10, 16'hA1A1);
    chk("R6 write hit no bus", n_log == 0, n_log, 0);
    snoop(2'd0, 8'h10, '0);
    chk("R6 line dirty after write", s_hit && s_dirty, {s_hit, s_dirty}, 3);
    chk("R10 snoop data", s_data == 16'hA1A1, s_data, 16'hA1A1);
    access(0, 8'h10, '0);
    chk("R10 snooped line invalid", n_log == 1 && lg_cmd[0] == 2'd0, n_log, 1);
  endtask

  task automatic t_write_pd;
    access(1, 8'h10, 16'hB0B0);
    access(1, 8'h10, 16'hC0C0);
    chk("R5 dirty write no bus", n_log == 0, n_log, 0);
    access(0, 8'h10, '0);
    chk("R5 dirty data", r_data == 16'hC0C0 && n_log == 0, r_data, 16'hC0C0);
  endtask

  task automatic t_evict;
    access(0, 8'h18, '0);
    chk("R12 two transactions", n_log == 2, n_log, 2);
    chk("R12 victim write-back", lg_cmd[0] == 2'd3 && lg_addr[0] == 8'h10 &&
        lg_data[0] == 16'hC0C0, lg_data[0], 16'hC0C0);
    chk("R12 fill after", lg_cmd[1] == 2'd0 && lg_addr[1] == 8'h18, lg_addr[1], 8'h18);
    chk("R12 fill data", r_data == 16'h1018, r_data, 16'h1018);
  endtask

  task automatic t_write_miss_excl;
    access(1, 8'h23, 16'hD3D3);
    chk("R9 ownership read", n_log == 1 && lg_cmd[0] == 2'd1, lg_cmd[0], 1);
    snoop(2'd1, 8'h23, '0);
    chk("R9 installed dirty", s_hit && s_dirty && s_data == 16'hD3D3, s_data, 16'hD3D3);
  endtask

  task automatic t_read_remote_dirty;
    rs_shd = 1; rs_dty = 1; rs_data = 16'h5A5A;
    access(0, 8'h41, '0);
    rs_shd = 0; rs_dty = 0;
    chk("R4 read then write-through", n_log == 2 && lg_cmd[0] == 2'd0 &&
        lg_cmd[1] == 2'd2, n_log, 2);
    chk("R4 written-through data", lg_data[1] == 16'h5A5A && mem[8'h41] == 16'h5A5A,
        lg_data[1], 16'h5A5A);
    chk("R4 data to core", r_data == 16'h5A5A, r_data, 16'h5A5A);
    access(0, 8'h41, '0);
    chk("R2 shared hit no bus", n_log == 0 && r_data == 16'h5A5A, n_log, 0);
    chk("R2 shared hit latency", r_lat == 1 && r_stall == 0, r_lat, 1);
  endtask

  task automatic t_write_shared;
    access(1, 8'h41, 16'h7777);
    chk("R7 one write-through", n_log == 1 && lg_cmd[0] == 2'd2 &&
        lg_data[0] == 16'h7777, lg_data[0], 16'h7777);
    chk("R7 stall held", r_stall == 1, r_stall, 1);
    access(0, 8'h41, '0);
    chk("R7 line kept", n_log == 0 && r_data == 16'h7777, r_data, 16'h7777);
  endtask

  task automatic t_snoop_shared;
    snoop(2'd0, 8'h41, '0);
    chk("R11 shared snoop clean hit", s_hit && !s_dirty && s_data == 16'h7777,
        s_data, 16'h7777);
    access(0, 8'h41, '0);
    chk("R11 shared kept", n_log == 0, n_log, 0);
    snoop(2'd2, 8'h41, 16'h0BAD);
    access(0, 8'h41, '0);
    chk("R11 remote update applied", n_log == 0 && r_data == 16'h0BAD, r_data, 16'h0BAD);
  endtask

  task automatic t_write_miss_shared;
    rs_shd = 1; rs_dty = 0; rs_data = 16'h1111;
    access(1, 8'h62, 16'h2222);
    rs_shd = 0;
    chk("R8 ownership then write-through", n_log == 2 && lg_cmd[0] == 2'd1 &&
        lg_cmd[1] == 2'd2 && lg_data[1] == 16'h2222, lg_data[1], 16'h2222);
    access(0, 8'h62, '0);
    chk("R8 shared installed", n_log == 0 && r_data == 16'h2222, r_data, 16'h2222);
  endtask

  task automatic t_defer;
    int lat;
    n_log = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h41;
    snp_valid = 1'b1; snp_cmd = 2'd3; snp_addr = 8'h99;
    lat = 0;
    @(negedge clk);
    snp_valid = 1'b0;
    lat++;
    while (!cpu_done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    cpu_req = 1'b0;
    chk("R13 request waits for snoop", lat == 2, lat, 2);
    chk("R13 deferred data", cpu_rdata == 16'h0BAD, cpu_rdata, 16'h0BAD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_fill();
    t_write_pe();
    t_write_pd();
    t_evict();
    t_write_miss_excl();
    t_read_remote_dirty();
    t_write_shared();
    t_snoop_shared();
    t_write_miss_shared();
    t_defer();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule